// File: doc/BRIEF.md
# Multi-Cycle Bubble Sorter

This block sorts a fixed-size array of small unsigned numbers into ascending order. It does one compare-and-swap of adjacent elements per clock cycle. A deep single-cycle comparator chain is never built. The array arrives in one beat on a valid/ready input. It is copied into a working register and sorted pass by pass in bubble-sort order. Each pass is one pair shorter than the pass before it, because that pass has moved the largest remaining element to the top end.

The sorter stops as soon as a whole pass makes no exchange. It also stops after the last possible pass, whichever comes first. The result is then copied into an output register, and a one-cycle valid pulse announces it. The input side follows valid/ready rules. A beat is taken only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high only while the sorter is idle, so a request offered during a sort is simply not taken. The output side has no back-pressure. `out_valid` is a single-cycle strobe. `out_data` then holds the result until the next sort completes, so a consumer may read it at any later time.

Top module: `bubble_sorter`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is all zeros.
- R2: A beat is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Element i of the array is `in_data[4*i+3:4*i]`, and the same layout is used for `out_data`.
- R3: The result is in ascending order with element 0 the smallest. Elements are compared as unsigned 4-bit numbers, so values 8 to 15 sort above values 0 to 7. The result is a permutation of the accepted elements.
- R4: Exactly one adjacent pair is compared per cycle. Pass p (counting from 0) compares the pairs at indices 0 through 14-p, in increasing order. If C pairs are compared in total, `out_valid` rises C+1 clock edges after the accepting edge.
- R5: The sort ends after the first pass that makes no exchange. An input that is already sorted completes after 15 compares (latency 16).
- R6: At most 15 passes run. A strictly descending input needs 120 compares (latency 121).
- R7: While a sort is in progress `in_ready` is 0. Any `in_valid` in that time is ignored: it neither changes the running sort nor produces an extra result.
- R8: `out_valid` is high for exactly one cycle per completed sort. `out_data` keeps its value until the next completion.
- R9: A reset during a sort abandons it. `in_ready` returns to 1, and no result is produced for the abandoned request.
- R10: Equal neighbours are never exchanged. An array of identical values finishes after a single pass of 15 compares.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input array offered |
| in_ready | output | 1 | Sorter idle and able to take an array |
| in_data | input | 64 | Packed input array, element i at bits 4i+3..4i |
| out_valid | output | 1 | One-cycle strobe: new sorted result on out_data |
| out_data | output | 64 | Packed sorted array, held between completions |

## Verification
The bench builds the sorter with its default 16 elements of 4 bits each. At this size the full worst case is within reach: a descending input takes all 15 passes and 120 compares. So is the one-pass early exit for sorted and constant inputs. The 4-bit width makes it cheap to include values on both sides of the top bit, which exposes any signed comparison. The bench checks each result and its exact latency against a model that counts compares. It also checks requests offered while busy, result holding after the strobe, and a reset that abandons a sort midway.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bsort_state_e;
endpackage

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
  import bsort_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             swap_now,
  output logic             idle_o,
  output logic             load_o,
  output logic             run_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_PASS = IDX_W'(NUM_ELEM - 2);

  bsort_state_e     state_q;
  logic [IDX_W-1:0] pass_q;
  logic [IDX_W-1:0] idx_q;
  logic             dirty_q;
  logic [IDX_W-1:0] last_idx;
  logic             pass_end;
  logic             pass_dirty;

  // highest pair index of the current pass shrinks by one each pass
  assign last_idx   = LAST_PASS - pass_q;
  assign pass_end   = (state_q == ST_RUN) && (idx_q == last_idx);
  assign pass_dirty = dirty_q | swap_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      idx_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            pass_q  <= '0;
            idx_q   <= '0;
            dirty_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (pass_end) begin
            if (!pass_dirty || (pass_q == LAST_PASS)) begin
              state_q <= ST_DONE;
            end else begin
              pass_q  <= pass_q + 1'b1;
              idx_q   <= '0;
              dirty_q <= 1'b0;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            dirty_q <= pass_dirty;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign load_o = idle_o && start;
  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign idx_o  = idx_q;

  // R7: a request while sorting never restarts or aborts the sort
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && start) |=> (state_q != ST_IDLE));

  // R6: the pass counter never goes beyond the last allowed pass
  assert_pass_bound_R6: assert property (@(posedge clk) disable iff (rst)
    run_o |-> (pass_q <= LAST_PASS));

  // R5: a clean pass ends the sort rather than starting another pass
  assert_early_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (pass_end && !pass_dirty) |=> (state_q == ST_DONE));
endmodule

// File: rtl/bsort_array.sv
module bsort_array #(
  parameter int NUM_ELEM = 16,
  parameter int ELEM_W   = 4,
  parameter int IDX_W    = $clog2(NUM_ELEM),
  parameter int FLAT_W   = NUM_ELEM * ELEM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [IDX_W-1:0]  idx,
  input  logic [FLAT_W-1:0] in_flat,
  output logic              swap_o,
  output logic [FLAT_W-1:0] work_flat
);
  logic [ELEM_W-1:0] work_q [NUM_ELEM];
  logic [IDX_W-1:0]  nxt;
  logic [ELEM_W-1:0] lo_val;
  logic [ELEM_W-1:0] hi_val;

  assign nxt    = idx + IDX_W'(1);
  assign lo_val = work_q[idx];
  assign hi_val = work_q[nxt];
  // unsigned compare; equal neighbours stay put
  assign swap_o = run && (lo_val > hi_val);

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NUM_ELEM; i++) begin
        work_q[i] <= in_flat[i*ELEM_W +: ELEM_W];
      end
    end else if (swap_o) begin
      work_q[idx] <= hi_val;
      work_q[nxt] <= lo_val;
    end
  end

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_flat
    assign work_flat[g*ELEM_W +: ELEM_W] = work_q[g];
  end

  // R3: after an exchange the touched pair is in order
  assert_swap_orders_pair_R3: assert property (@(posedge clk) disable iff (rst)
    swap_o |=> (work_q[$past(idx)] <= work_q[$past(nxt)]));

  // R10: equal neighbours are never exchanged
  assert_equal_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (run && lo_val == hi_val) |-> !swap_o);
endmodule

// File: rtl/bubble_sorter.sv
module bubble_sorter #(
  parameter int NUM_ELEM = 16,
  parameter int ELEM_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [NUM_ELEM*ELEM_W-1:0]   in_data,
  output logic                         out_valid,
  output logic [NUM_ELEM*ELEM_W-1:0]   out_data
);
  localparam int IDX_W  = $clog2(NUM_ELEM);
  localparam int FLAT_W = NUM_ELEM * ELEM_W;

  logic              idle, load, run, done, swap_now;
  logic [IDX_W-1:0]  idx;
  logic [FLAT_W-1:0] work_flat;

  bsort_ctrl #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (in_valid),
    .swap_now (swap_now),
    .idle_o   (idle),
    .load_o   (load),
    .run_o    (run),
    .done_o   (done),
    .idx_o    (idx)
  );

  bsort_array #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .IDX_W(IDX_W), .FLAT_W(FLAT_W)) u_array (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .run       (run),
    .idx       (idx),
    .in_flat   (in_data),
    .swap_o    (swap_now),
    .work_flat (work_flat)
  );

  assign in_ready = idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= done;
      if (done) out_data <= work_flat;
    end
  end

  // R8: strobe lasts one cycle
  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: result held between completions
  assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R7: no acceptance while a result is being produced
  assert_ready_low_busy_R7: assert property (@(posedge clk) disable iff (rst)
    run |-> !in_ready);

  // R3: every published result is ascending
  for (genvar k = 0; k < NUM_ELEM - 1; k++) begin : g_order
    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data[k*ELEM_W +: ELEM_W] <= out_data[(k+1)*ELEM_W +: ELEM_W]));
  end
endmodule

// File: tb/bubble_sorter_bench.sv
`timescale 1ns/1ps
module bubble_sorter_bench;
  localparam int N = 16;
  localparam int W = 4;
  localparam int F = N * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [F-1:0] in_data = '0;
  logic         in_ready;
  logic         out_valid;
  logic [F-1:0] out_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic         prev_ov = 1'b0;
  logic [F-1:0] last_out = '0;

  logic [F-1:0] exp_q[$];
  int           lat_q[$];
  int           acc_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bubble_sorter u_bubble_sorter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [F-1:0] act, input logic [F-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference: bubble sort with early exit, counting compares
  function automatic logic [F-1:0] model_sort(input logic [F-1:0] v, output int cmps);
    int a[N];
    logic [F-1:0] r;
    for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
    cmps = 0;
    for (int p = 0; p < N - 1; p++) begin
      bit sw = 1'b0;
      for (int i = 0; i < N - 1 - p; i++) begin
        cmps++;
        if (a[i] > a[i+1]) begin
          int t = a[i]; a[i] = a[i+1]; a[i+1] = t; sw = 1'b1;
        end
      end
      if (!sw) break;
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(a[i]);
    return r;
  endfunction

  task automatic send(input logic [F-1:0] v, input string tag);
    int c;
    logic [F-1:0] s;
    s = model_sort(v, c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    in_valid = 1'b0;
    exp_q.push_back(s);
    lat_q.push_back(c + 1);
    acc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7/R9 unexpected result", out_data, '0);
        end else begin
          logic [F-1:0] e;
          int l, a;
          string t;
          e = exp_q.pop_front(); l = lat_q.pop_front();
          a = acc_q.pop_front(); t = tag_q.pop_front();
          chk(out_data == e, {t, " R2 R3 sorted data"}, out_data, e);
          chk((cyc - a) == l, {t, " R4 latency"}, F'(cyc - a), F'(l));
          last_out = out_data;
        end
      end
      if (out_valid && prev_ov) chk(1'b0, "R8 strobe longer than one cycle", 1, 0);
      prev_ov = out_valid;
    end else begin
      prev_ov = 1'b0;
    end
  end

  function automatic logic [F-1:0] mix(input logic [F-1:0] s);
    logic [F-1:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
    return x;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R4 watchdog expired act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [F-1:0] v;
    logic [F-1:0] seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready after reset", F'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", F'(out_valid), 0);
    chk(out_data == '0, "R1 out_data after reset", out_data, '0);

    // R6: strictly descending, full 15 passes
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(N - 1 - i);
    send(v, "R6 descending");
    wait_empty();

    // R5: already sorted
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i);
    send(v, "R5 presorted");
    wait_empty();

    // R10: all equal
    for (int i = 0; i < N; i++) v[i*W +: W] = 4'h7;
    send(v, "R10 all equal");
    wait_empty();

    // R3: values straddling the top bit
    for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2 == 0) ? W'(8 + i / 2) : W'(7 - i / 2);
    send(v, "R3 top-bit mix");
    wait_empty();

    // R4: assorted patterns
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 6; k++) begin
      seed = mix(seed);
      send(seed, "R4 pattern");
      wait_empty();
    end

    // R7: request during a sort is ignored
    for (int i = 0; i < N; i++) v[i*W +: W] = W'((i * 5) % N);
    send(v, "R7 busy");
    for (int k = 0; k < 3; k++) begin
      chk(in_ready == 1'b0, "R7 in_ready low while busy", F'(in_ready), 0);
      in_valid = 1'b1;
      in_data  = '1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_empty();

    // R8: result held after the strobe
    v = last_out;
    repeat (5) @(negedge clk);
    chk(out_data == v, "R8 out_data held", out_data, v);
    chk(out_valid == 1'b0, "R8 out_valid low after strobe", F'(out_valid), 0);

    // R9: reset in the middle of a sort
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(N - 1 - i);
    @(negedge clk);
    in_valid = 1'b1; in_data = v;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 in_ready after abort", F'(in_ready), 1);
    chk(out_valid == 1'b0, "R9 out_valid after abort", F'(out_valid), 0);
    repeat (130) @(negedge clk);
    chk(exp_q.size() == 0, "R9 no pending results", F'(exp_q.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule